// File: doc/BRIEF.md
# Packet-Command Disc Interface PIO Transfer Controller

This block is the device side of a packet-command disc interface. A host reaches it through a small register window. The window has a 16-bit data port and byte-wide registers for error/feature, transfer direction (count), a 16-bit byte count, status/command and control. The host issues the packet command and then writes a 12-byte command packet through the data port. The block hands those six words to a downstream parser and pulses a ready strobe.

The parser fills an internal response RAM through a side write port. It then requests a PIO read of a given byte length. The host pulls the response out one 16-bit word at a time. The transfer is cut into blocks whose length the host set in the byte-count registers before it issued the packet. An interrupt is raised when the read starts, at every block boundary and at the end of the transfer. A single pending flag is set by those events. It is cleared by any command write and by a status read while the device is not busy. The flag drives the interrupt line unless the control register masks it.

Top module: `atapi_pio_xfer`

## Requirements
- R1: After reset, a status read (address 5) returns 0x50, the data port (address 0) reads 0, and `irqOut` is low. Register addresses are: 0 data, 1 error (read) / feature (write), 2 count, 3 byte count low, 4 byte count high, 5 status (read) / command (write), 6 control. Registers appear in bits 7:0 of `hostRdData`.
- R2: Writing command 0xA0 sets status to 0x48 and count to 0x01, and copies feature bits 1:0 into the error register.
- R3: After the sixth data write following 0xA0, `pktReady` is high for exactly one cycle. `pktData` holds word i of the packet in bits 16i+15:16i, and status reads 0xC0.
- R4: `startRead` is accepted only in the busy state that follows a complete packet. It sets count to 0x02, loads the byte-count registers with `rdLength`, sets status to 0x48 and raises an interrupt. In any other state it has no effect.
- R5: Each data read in the read state returns the next RAM word, starting at word 0 and advancing 2 bytes per read. When the byte offset reaches or passes the length, status becomes 0x40, the state returns to idle and an interrupt is raised.
- R6: The block length is the byte count held at the 0xA0 write. A value of 0 means the whole transfer length. Whenever a read that is not the last one exhausts a block, the block counter reloads and an interrupt is raised.
- R7: Raising an interrupt while one is pending has no further effect. `irqOut` equals the pending flag while control bit 1 is 0, and is low while that bit is 1.
- R8: A status read while status bit 7 (busy) is clear clears the pending interrupt.
- R9: Every command write clears the pending interrupt. Command 0x00 then returns to idle, sets status 0x51 and raises an interrupt. Other command codes change nothing else.
- R10: Data writes outside the packet-collection state and data reads outside the read state change nothing, and such reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostRdEn | input | 1 | Host register read strobe (side effects on status and data) |
| hostAddr | input | 3 | Host register address |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Host read data, combinational from hostAddr |
| bufWrEn | input | 1 | Response RAM write enable |
| bufWrAddr | input | BUF_AW (8) | Response RAM word address |
| bufWrData | input | 16 | Response RAM write data |
| startRead | input | 1 | Parser request to start the PIO read |
| rdLength | input | LEN_W (16) | Read transfer length in bytes |
| pktReady | output | 1 | One-cycle strobe: command packet complete |
| pktData | output | 96 | Collected command packet, six words |
| irqOut | output | 1 | Interrupt request to the host |

## Verification
The bench targets block-boundary timing. A design that reloads the block counter one read late, or raises the interrupt on the final read as a block event rather than an end event, moves the interrupt by a word. An odd length and a zero block length are covered too. A wrong comparison there either over-reads or never ends the transfer. Masking is toggled while an interrupt is pending, and a command write is made with an interrupt pending. A design that drops the pending flag when masked, or keeps it across a command, shows the wrong level on `irqOut`. Stray data-port accesses and a `startRead` outside the busy state are also issued. A design that does not gate these on the state corrupts the packet or starts a read.

// File: rtl/atapi_pio_pkg.sv
package atapi_pio_pkg;

  typedef enum logic [1:0] {
    XS_IDLE,
    XS_CMDIN,
    XS_BUSY,
    XS_RDOUT
  } xferState_e;

  typedef struct packed {
    logic enterCmd;
    logic pktWrite;
    logic enterRead;
    logic readStep;
    logic readOpen;
  } dpStrobe_t;

  localparam logic [2:0] RA_DATA    = 3'd0;
  localparam logic [2:0] RA_ERRFEAT = 3'd1;
  localparam logic [2:0] RA_COUNT   = 3'd2;
  localparam logic [2:0] RA_BCLO    = 3'd3;
  localparam logic [2:0] RA_BCHI    = 3'd4;
  localparam logic [2:0] RA_STATCMD = 3'd5;
  localparam logic [2:0] RA_CTRL    = 3'd6;

  localparam int unsigned SB_BSY = 7;
  localparam int unsigned SB_DRQ = 3;
  localparam int unsigned CTRL_MASK_BIT = 1;

  localparam logic [7:0] STAT_RESET = 8'h50;
  localparam logic [7:0] STAT_XFER  = 8'h48;
  localparam logic [7:0] STAT_ABORT = 8'h51;

  localparam logic [7:0] CMD_PACKET = 8'hA0;
  localparam logic [7:0] CMD_NOP    = 8'h00;

  localparam logic [7:0] CNT_TO_DEV = 8'h01;
  localparam logic [7:0] CNT_TO_HOST = 8'h02;

endpackage

// File: rtl/atapi_pio_fsm.sv
module atapi_pio_fsm
  import atapi_pio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWrEn,
  input  logic       hostRdEn,
  input  logic [2:0] hostAddr,
  input  logic [7:0] cmdByte,
  input  logic       startRead,
  input  logic       pktLast,
  input  logic       lastStep,
  input  logic       blkEnd,
  output dpStrobe_t  strobe,
  output logic [7:0] statusVal,
  output logic       irqPending,
  output logic       pktReady
);

  xferState_e state, stateNxt;
  logic [7:0] statusNxt;
  logic       raiseIrq, clearIrq, pktRdyNxt, cmdWr;

  always_comb begin
    stateNxt  = state;
    statusNxt = statusVal;
    raiseIrq  = 1'b0;
    clearIrq  = 1'b0;
    pktRdyNxt = 1'b0;
    strobe    = '0;
    strobe.readOpen = (state == XS_RDOUT);
    cmdWr = hostWrEn && (hostAddr == RA_STATCMD);

    if (cmdWr) begin
      clearIrq = 1'b1;
      if (cmdByte == CMD_PACKET) begin
        stateNxt        = XS_CMDIN;
        statusNxt       = STAT_XFER;
        strobe.enterCmd = 1'b1;
      end else if (cmdByte == CMD_NOP) begin
        stateNxt  = XS_IDLE;
        statusNxt = STAT_ABORT;
        raiseIrq  = 1'b1;
      end
    end else begin
      if (hostWrEn && hostAddr == RA_DATA && state == XS_CMDIN) begin
        strobe.pktWrite = 1'b1;
        if (pktLast) begin
          stateNxt          = XS_BUSY;
          statusNxt[SB_DRQ] = 1'b0;
          statusNxt[SB_BSY] = 1'b1;
          pktRdyNxt         = 1'b1;
        end
      end
      if (hostRdEn && hostAddr == RA_DATA && state == XS_RDOUT) begin
        strobe.readStep = 1'b1;
        if (lastStep) begin
          stateNxt          = XS_IDLE;
          statusNxt[SB_DRQ] = 1'b0;
          raiseIrq          = 1'b1;
        end else if (blkEnd) begin
          raiseIrq = 1'b1;
        end
      end
      if (hostRdEn && hostAddr == RA_STATCMD && !statusVal[SB_BSY]) begin
        clearIrq = 1'b1;
      end
      if (startRead && state == XS_BUSY) begin
        strobe.enterRead = 1'b1;
        stateNxt         = XS_RDOUT;
        statusNxt        = STAT_XFER;
        raiseIrq         = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= XS_IDLE;
      statusVal  <= STAT_RESET;
      irqPending <= 1'b0;
      pktReady   <= 1'b0;
    end else begin
      state      <= stateNxt;
      statusVal  <= statusNxt;
      irqPending <= raiseIrq | (irqPending & ~clearIrq);
      pktReady   <= pktRdyNxt;
    end
  end

endmodule

// File: rtl/atapi_pio_dpath.sv
module atapi_pio_dpath
  import atapi_pio_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int BUF_WORDS = 256,
  parameter int PKT_WORDS = 6,
  localparam int BUF_AW   = $clog2(BUF_WORDS),
  localparam int PKT_IW   = $clog2(PKT_WORDS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic [7:0]             statusVal,
  input  logic                   hostWrEn,
  input  logic [2:0]             hostAddr,
  input  logic [15:0]            hostWrData,
  output logic [15:0]            hostRdData,
  input  logic                   bufWrEn,
  input  logic [BUF_AW-1:0]      bufWrAddr,
  input  logic [15:0]            bufWrData,
  input  logic [LEN_W-1:0]       rdLength,
  output logic [16*PKT_WORDS-1:0] pktData,
  output logic                   irqMask,
  output logic                   pktLast,
  output logic                   lastStep,
  output logic                   blkEnd
);

  logic [7:0] featureReg, errorReg, countReg, bcLoReg, bcHiReg, ctrlReg;
  logic [LEN_W-1:0] blockLen, totalLen, offset, blockLeft, blockReload;
  logic [LEN_W:0]   nextOff;
  logic [PKT_IW-1:0] pktIdx;
  logic [15:0] pktMem [PKT_WORDS];
  logic [15:0] bufMem [BUF_WORDS];
  logic [15:0] rdWord;
  logic [LEN_W-1:0] readReload;

  assign nextOff    = {1'b0, offset} + (LEN_W+1)'(2);
  assign lastStep   = nextOff >= {1'b0, totalLen};
  assign blkEnd     = blockLeft <= LEN_W'(2);
  assign pktLast    = pktIdx == PKT_IW'(PKT_WORDS-1);
  assign irqMask    = ctrlReg[CTRL_MASK_BIT];
  assign rdWord     = bufMem[offset[BUF_AW:1]];
  assign readReload = (blockLen == '0) ? rdLength : blockLen;

  for (genvar gi = 0; gi < PKT_WORDS; gi++) begin : g_pkt
    assign pktData[16*gi +: 16] = pktMem[gi];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      featureReg  <= '0;
      errorReg    <= '0;
      countReg    <= '0;
      bcLoReg     <= '0;
      bcHiReg     <= '0;
      ctrlReg     <= '0;
      blockLen    <= '0;
      totalLen    <= '0;
      offset      <= '0;
      blockLeft   <= '0;
      blockReload <= '0;
      pktIdx      <= '0;
    end else begin
      if (hostWrEn) begin
        case (hostAddr)
          RA_ERRFEAT: featureReg <= hostWrData[7:0];
          RA_COUNT:   countReg   <= hostWrData[7:0];
          RA_BCLO:    bcLoReg    <= hostWrData[7:0];
          RA_BCHI:    bcHiReg    <= hostWrData[7:0];
          RA_CTRL:    ctrlReg    <= hostWrData[7:0];
          default: ;
        endcase
      end
      if (strobe.enterCmd) begin
        errorReg <= {6'b0, featureReg[1:0]};
        countReg <= CNT_TO_DEV;
        blockLen <= LEN_W'({bcHiReg, bcLoReg});
        pktIdx   <= '0;
      end
      if (strobe.pktWrite) begin
        pktIdx <= pktIdx + PKT_IW'(1);
      end
      if (strobe.enterRead) begin
        countReg    <= CNT_TO_HOST;
        bcLoReg     <= rdLength[7:0];
        bcHiReg     <= 8'(rdLength >> 8);
        totalLen    <= rdLength;
        offset      <= '0;
        blockReload <= readReload;
        blockLeft   <= readReload;
      end
      if (strobe.readStep) begin
        offset    <= nextOff[LEN_W-1:0];
        blockLeft <= blkEnd ? blockReload : blockLeft - LEN_W'(2);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.pktWrite) pktMem[pktIdx] <= hostWrData;
  end

  always_ff @(posedge clk) begin
    if (bufWrEn) bufMem[bufWrAddr] <= bufWrData;
  end

  always_comb begin
    case (hostAddr)
      RA_DATA:    hostRdData = strobe.readOpen ? rdWord : 16'h0;
      RA_ERRFEAT: hostRdData = {8'h0, errorReg};
      RA_COUNT:   hostRdData = {8'h0, countReg};
      RA_BCLO:    hostRdData = {8'h0, bcLoReg};
      RA_BCHI:    hostRdData = {8'h0, bcHiReg};
      RA_STATCMD: hostRdData = {8'h0, statusVal};
      RA_CTRL:    hostRdData = {8'h0, ctrlReg};
      default:    hostRdData = 16'h0;
    endcase
  end

endmodule

// File: rtl/atapi_pio_xfer.sv
module atapi_pio_xfer
  import atapi_pio_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int BUF_WORDS = 256,
  localparam int BUF_AW   = $clog2(BUF_WORDS),
  localparam int PKT_WORDS = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    hostWrEn,
  input  logic                    hostRdEn,
  input  logic [2:0]              hostAddr,
  input  logic [15:0]             hostWrData,
  output logic [15:0]             hostRdData,
  input  logic                    bufWrEn,
  input  logic [BUF_AW-1:0]       bufWrAddr,
  input  logic [15:0]             bufWrData,
  input  logic                    startRead,
  input  logic [LEN_W-1:0]        rdLength,
  output logic                    pktReady,
  output logic [16*PKT_WORDS-1:0] pktData,
  output logic                    irqOut
);

  dpStrobe_t  strobe;
  logic [7:0] statusVal;
  logic       irqPending, irqMask, pktLast, lastStep, blkEnd;

  atapi_pio_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .hostWrEn   (hostWrEn),
    .hostRdEn   (hostRdEn),
    .hostAddr   (hostAddr),
    .cmdByte    (hostWrData[7:0]),
    .startRead  (startRead),
    .pktLast    (pktLast),
    .lastStep   (lastStep),
    .blkEnd     (blkEnd),
    .strobe     (strobe),
    .statusVal  (statusVal),
    .irqPending (irqPending),
    .pktReady   (pktReady)
  );

  atapi_pio_dpath #(
    .LEN_W     (LEN_W),
    .BUF_WORDS (BUF_WORDS),
    .PKT_WORDS (PKT_WORDS)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .statusVal  (statusVal),
    .hostWrEn   (hostWrEn),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .bufWrEn    (bufWrEn),
    .bufWrAddr  (bufWrAddr),
    .bufWrData  (bufWrData),
    .rdLength   (rdLength),
    .pktData    (pktData),
    .irqMask    (irqMask),
    .pktLast    (pktLast),
    .lastStep   (lastStep),
    .blkEnd     (blkEnd)
  );

  assign irqOut = irqPending & ~irqMask;

endmodule

// File: rtl/atapi_pio_chk.sv
module atapi_pio_chk
  import atapi_pio_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        hostWrEn,
  input logic        hostRdEn,
  input logic [2:0]  hostAddr,
  input logic [15:0] hostWrData,
  input logic        irqOut,
  input logic        pktReady,
  input logic [7:0]  statusVal,
  input logic        irqPending
);

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == RA_CTRL && hostWrData[1]) |=> !irqOut); // R7

  AST_UNMASK_SHOWS: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == RA_CTRL && !hostWrData[1] && irqPending) |=> irqOut); // R7

  AST_PKT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pktReady |=> !pktReady); // R3

  AST_PKT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    pktReady |-> statusVal == 8'hC0); // R3

  AST_NOP_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == RA_STATCMD && hostWrData[7:0] == 8'h00)
      |=> (statusVal == 8'h51 && irqPending)); // R9

  AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == RA_STATCMD && hostWrData[7:0] != 8'h00) |=> !irqPending); // R9

  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && !hostWrEn && hostAddr == RA_STATCMD && !statusVal[7]) |=> !irqPending); // R8

endmodule

bind atapi_pio_xfer atapi_pio_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostWrEn   (hostWrEn),
  .hostRdEn   (hostRdEn),
  .hostAddr   (hostAddr),
  .hostWrData (hostWrData),
  .irqOut     (irqOut),
  .pktReady   (pktReady),
  .statusVal  (statusVal),
  .irqPending (irqPending)
);

// File: tb/tb_atapi_pio_xfer.sv
module tb_atapi_pio_xfer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 0, hostRdEn = 0, bufWrEn = 0, startRead = 0;
  logic [2:0]  hostAddr = 0;
  logic [15:0] hostWrData = 0, bufWrData = 0, rdLength = 0;
  logic [7:0]  bufWrAddr = 0;
  logic [15:0] hostRdData;
  logic        pktReady, irqOut;
  logic [95:0] pktData;

  atapi_pio_xfer dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData),
    .startRead(startRead), .rdLength(rdLength), .pktReady(pktReady),
    .pktData(pktData), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nCmp = 0, nBad = 0;

  // behavioural reference state
  int mState = 0;               // 0 idle, 1 packet in, 2 busy, 3 read out
  int mStatus = 'h50, mErr = 0, mCount = 0, mFeat = 0, mBcLo = 0, mBcHi = 0, mCtl = 0;
  int mBlkLen = 0, mTot = 0, mOff = 0, mBlkLeft = 0, mReload = 0;
  bit mPend = 0, mPktRdy = 0;
  int mMem [256];
  int mPktQ [$];
  int mPktW [6];

  task automatic chk(input string tag, input int got, input int exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int modelRead(input int a);
    case (a)
      0: return (mState == 3) ? mMem[(mOff / 2) % 256] : 0;
      1: return mErr;
      2: return mCount;
      3: return mBcLo;
      4: return mBcHi;
      5: return mStatus;
      6: return mCtl;
      default: return 0;
    endcase
  endfunction

  task automatic modelStep(input bit wr, input bit rd, input int a, input int d,
                           input bit sr, input int slen);
    bit raise = 0, clr = 0, cmdWr;
    mPktRdy = 0;
    cmdWr = wr && a == 5;
    if (cmdWr) begin
      clr = 1;
      if ((d & 'hFF) == 'hA0) begin
        mState = 1; mStatus = 'h48; mErr = mFeat & 3; mCount = 1;
        mBlkLen = mBcHi * 256 + mBcLo; mPktQ.delete();
      end else if ((d & 'hFF) == 0) begin
        mState = 0; mStatus = 'h51; raise = 1;
      end
    end
    if (wr && a == 0 && mState == 1) begin
      mPktQ.push_back(d);
      if (mPktQ.size() == 6) begin
        mState = 2; mStatus = 'hC0; mPktRdy = 1;
        for (int i = 0; i < 6; i++) mPktW[i] = mPktQ[i];
      end
    end
    if (wr && a == 1) mFeat = d & 'hFF;
    if (wr && a == 2) mCount = d & 'hFF;
    if (wr && a == 3) mBcLo = d & 'hFF;
    if (wr && a == 4) mBcHi = d & 'hFF;
    if (wr && a == 6) mCtl = d & 'hFF;
    if (rd && a == 5 && (mStatus & 'h80) == 0) clr = 1;
    if (rd && a == 0 && mState == 3) begin
      mOff += 2;
      if (mOff >= mTot) begin
        mState = 0; mStatus = mStatus & ~'h08; raise = 1;
      end else begin
        mBlkLeft -= 2;
        if (mBlkLeft <= 0) begin mBlkLeft = mReload; raise = 1; end
      end
    end
    if (sr && mState == 2 && !cmdWr) begin
      mState = 3; mStatus = 'h48; mCount = 2;
      mBcLo = slen & 'hFF; mBcHi = (slen >> 8) & 'hFF;
      mTot = slen; mOff = 0;
      mReload = (mBlkLen == 0) ? slen : mBlkLen;
      mBlkLeft = mReload; raise = 1;
    end
    if (raise) mPend = 1; else if (clr) mPend = 0;
  endtask

  // one clock: drive at the low phase, check reads before the edge, outputs after it
  task automatic step(input bit wr, input bit rd, input int a, input int d,
                      input bit sr, input int slen, input string tag);
    hostWrEn = wr; hostRdEn = rd; hostAddr = 3'(a); hostWrData = 16'(d);
    startRead = sr; rdLength = 16'(slen);
    #1;
    if (rd) chk({tag, " read"}, int'(hostRdData), modelRead(a));
    modelStep(wr, rd, a, d, sr, slen);
    @(posedge clk); #1;
    chk("R7 irqOut", int'(irqOut), int'(mPend && (mCtl & 2) == 0));
    chk("R3 pktReady", int'(pktReady), int'(mPktRdy));
    if (mPktRdy) for (int i = 0; i < 6; i++) chk("R3 pktData", int'(pktData[16*i +: 16]), mPktW[i]);
    hostWrEn = 0; hostRdEn = 0; startRead = 0; bufWrEn = 0;
    @(negedge clk);
  endtask

  task automatic wrReg(input int a, input int d, input string tag);
    step(1, 0, a, d, 0, 0, tag);
  endtask

  task automatic rdChk(input int a, input int exp, input string tag);
    hostAddr = 3'(a); #1;
    chk(tag, int'(hostRdData), exp);
    step(0, 1, a, 0, 0, 0, tag);
  endtask

  task automatic rdData(input string tag);
    step(0, 1, 0, 0, 0, 0, tag);
  endtask

  task automatic sRead(input int len, input string tag);
    step(0, 0, 0, 0, 1, len, tag);
  endtask

  task automatic sendPacket(input int bcount, input int base);
    wrReg(3, bcount & 'hFF, "R6");
    wrReg(4, bcount >> 8, "R6");
    wrReg(5, 'hA0, "R2");
    for (int i = 0; i < 6; i++) wrReg(0, base + i, "R3");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", int'(irqOut), 0);
    rdChk(5, 'h50, "R1 status");
    rdChk(0, 0, "R1 data");
    // R10 stray data port accesses in idle
    wrReg(0, 'h1234, "R10");
    rdChk(5, 'h50, "R10 status");
    rdChk(0, 0, "R10 data idle");
    // R4 start request outside busy ignored
    sRead(8, "R4");
    rdChk(5, 'h50, "R4 status idle");
    rdChk(2, 0, "R4 count idle");
    chk("R4 irq idle", int'(irqOut), 0);
    // response RAM contents
    for (int k = 0; k < 16; k++) begin
      bufWrEn = 1; bufWrAddr = 8'(k); bufWrData = 16'('hA000 + 3 * k);
      mMem[k] = 'hA000 + 3 * k;
      step(0, 0, 0, 0, 0, 0, "load");
    end
    // R2 packet command
    wrReg(1, 'h07, "R2");
    wrReg(3, 8, "R6");
    wrReg(4, 0, "R6");
    wrReg(5, 'hA0, "R2");
    rdChk(5, 'h48, "R2 status");
    rdChk(1, 'h03, "R2 error");
    rdChk(2, 'h01, "R2 count");
    // R3 six packet words
    for (int i = 0; i < 5; i++) wrReg(0, 'h1100 + i, "R3");
    wrReg(0, 'h1105, "R3");
    chk("R3 pulse", int'(pktReady), 1);
    chk("R3 word5", int'(pktData[95:80]), 'h1105);
    rdChk(5, 'hC0, "R3 busy status");
    chk("R3 pulse gone", int'(pktReady), 0);
    rdChk(0, 0, "R10 data busy");
    // R4 start read of 20 bytes, block 8
    sRead(20, "R4");
    chk("R4 irq", int'(irqOut), 1);
    rdChk(2, 'h02, "R4 count");
    rdChk(3, 20, "R4 bclo");
    rdChk(4, 0, "R4 bchi");
    rdChk(5, 'h48, "R4 status");
    chk("R8 cleared", int'(irqOut), 0);
    // R6 block boundaries after bytes 8 and 16, R5 end at 20
    for (int i = 0; i < 3; i++) rdData("R5");
    chk("R6 no irq mid-block", int'(irqOut), 0);
    rdData("R5");
    chk("R6 block irq", int'(irqOut), 1);
    rdChk(5, 'h48, "R8");
    chk("R8 cleared 2", int'(irqOut), 0);
    for (int i = 0; i < 4; i++) rdData("R5");
    chk("R6 block irq 2", int'(irqOut), 1);
    rdData("R5");
    rdData("R5");
    chk("R7 end while pending", int'(irqOut), 1);
    rdChk(5, 'h40, "R5 end status");
    chk("R5 irq cleared", int'(irqOut), 0);
    rdChk(0, 0, "R10 data after end");
    // R7 masking with R9 abort
    wrReg(6, 2, "R7");
    wrReg(5, 'h00, "R9");
    chk("R7 masked", int'(irqOut), 0);
    wrReg(6, 0, "R7");
    chk("R7 unmasked", int'(irqOut), 1);
    wrReg(6, 2, "R7");
    chk("R7 remasked", int'(irqOut), 0);
    wrReg(6, 0, "R7");
    wrReg(5, 'h33, "R9");
    chk("R9 cmd clears", int'(irqOut), 0);
    rdChk(5, 'h51, "R9 status kept");
    // R9 abort in the middle of a packet
    wrReg(5, 'hA0, "R2");
    wrReg(0, 'h2200, "R3");
    wrReg(0, 'h2201, "R3");
    wrReg(5, 'h00, "R9");
    chk("R9 abort irq", int'(irqOut), 1);
    for (int i = 0; i < 6; i++) wrReg(0, 'h3300 + i, "R10");
    chk("R10 no packet", int'(pktReady), 0);
    rdChk(5, 'h51, "R9 abort status");
    // R6 zero block length: only the end interrupt
    sendPacket(0, 'h4400);
    sRead(6, "R4");
    rdChk(5, 'h48, "R8");
    rdData("R5");
    rdData("R5");
    chk("R6 zero block no irq", int'(irqOut), 0);
    rdData("R5");
    chk("R5 end irq", int'(irqOut), 1);
    rdChk(5, 'h40, "R5 status");
    // R5 odd length 5 with 2-byte blocks
    sendPacket(2, 'h5500);
    sRead(5, "R4");
    rdChk(5, 'h48, "R8");
    rdData("R6");
    chk("R6 two-byte block irq", int'(irqOut), 1);
    rdChk(5, 'h48, "R8");
    rdData("R6");
    rdChk(5, 'h48, "R8");
    rdData("R5");
    chk("R5 odd end irq", int'(irqOut), 1);
    rdChk(5, 'h40, "R5 odd status");
    rdChk(0, 0, "R10 after odd");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule